// File: doc/BRIEF.md
# Twin Timer/Counter

This block holds two independent timer/counter units. Each unit keeps a 16-bit count as a low byte and a high byte. A shared mode register picks, for each unit, one of four counting modes. The modes are a 13-bit prescaled count, a full 16-bit count, an 8-bit count with automatic reload, and a split mode in which unit 0 becomes two separate 8-bit counters. A shared control register holds one run bit and one overflow flag for each unit. The mode register also picks the count source for each unit: the one-clock machine-cycle tick input, or falling edges on an external event pin. A gate option makes a unit count only while its gate pin is high.

Software reaches all six registers over a simple byte-wide register bus. Writes take effect on the clock edge. Reads are combinational from the address. The prescaler that produces the tick, the interrupt logic that consumes the flags, and any serial baud use are outside the block.

The counting mode works as a per-unit selector with four named states:
- `MODE_W13` (code 00)
- `MODE_W16` (code 01)
- `MODE_RLD8` (code 10)
- `MODE_SPLIT` (code 11)

A unit changes between them only when software writes the mode register. The mode-dependent events are:
- carry from low field into high byte
- wrap to zero with flag set
- reload of the low byte from the high byte
- split-mode high-byte wrap, which is routed to flag 1

Top module: `twin_timer_counter`

## Requirements
- R1: After reset, every register reads 0. The register addresses are: 0 control, 1 mode, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low, 5 unit-1 high. The control register holds run0 at bit 0, run1 at bit 1, flag0 at bit 4 and flag1 at bit 5; its other bits read 0. The mode register holds unit 0 in bits 3:0 and unit 1 in bits 7:4. Within each nibble, bits 1:0 are the mode, bit 2 selects external events and bit 3 enables gating.
- R2: A write stores its value. The mode and counter registers read back the full written byte. The control register reads back only its four defined bits.
- R3: In mode 01, each count event adds 1 to {high,low} modulo 65536. A wrap from FFFF to 0000 sets the unit's flag.
- R4: In mode 00, {high byte, low byte bits 4:0} forms a 13-bit count that adds 1 per event. Low byte bits 7:5 keep their written value. A wrap from 1FFF to 0 sets the flag.
- R5: In mode 10, an event on a low byte of FF loads the high byte into the low byte and sets the flag; otherwise the low byte adds 1. The high byte is unchanged.
- R6: With the unit's run bit at 0, no tick changes the unit's count.
- R7: With gating enabled, a unit counts only while its synchronized gate pin is high.
- R8: With external events selected, a unit adds 1 per falling edge of its event pin and ignores the tick input.
- R9: Writing 0 to a flag bit clears it. A hardware set in the same cycle as that write wins.
- R10: With unit 0 in mode 11, its low byte counts under run0 and gating/source rules and sets flag0 on wrap. Its high byte counts ticks under run1 and sets flag1 on wrap.
- R11: While unit 0 is in mode 11, unit 1 keeps counting in its own mode under run1 but its wrap never sets flag1.
- R12: A unit 1 set to mode 11 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock machine-cycle tick |
| evt_pin_i | input | 2 | External event pins, one per unit |
| gate_pin_i | input | 2 | External gate pins, one per unit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |

## Verification
The 16-bit and 13-bit modes are swept over start values and tick counts that do and do not cross the wrap point. This separates a correct carry from a missing carry, and a wrap that flags from one that does not. The reload mode is tried with reload values that are ordinary, zero and all-ones, so a reload from the wrong byte is caught.

Split mode is driven so that unit 1 wraps while unit 0's high byte does not, and the other way round. This tells apart the two possible sources of flag1. Event counting is run with the tick held high, so a unit that still counted ticks would show it. The flag-clear test lands a software clear on the very cycle of a wrap.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned RUN_LSB   = 0;
    localparam int unsigned FLAG_LSB  = 4;
    localparam int unsigned NIB_W     = 4;

    typedef enum logic [1:0] {
        MODE_W13   = 2'b00,
        MODE_W16   = 2'b01,
        MODE_RLD8  = 2'b10,
        MODE_SPLIT = 2'b11
    } tc_mode_e;

    localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] REG_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] REG_LO0  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_HI0  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_LO1  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_HI1  = 3'd5;
endpackage

// File: rtl/tc_pin_sync.sv
module tc_pin_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign level_o = s2_q;
    assign fall_o  = prev_q & ~s2_q;
endmodule

// File: rtl/tc_unit.sv
module tc_unit
    import tc_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned LOW13_W  = 5,
    parameter bit          SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tc_mode_e          mode_i,
    input  logic              ev_main_i,
    input  logic              ev_hi_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              wrap_main_o,
    output logic              wrap_hi_o
);
    localparam logic [LOW13_W-1:0] LOW_FULL = '1;

    logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    always_comb begin
        lo_n        = lo_q;
        hi_n        = hi_q;
        wrap_main_o = 1'b0;
        wrap_hi_o   = 1'b0;
        unique case (mode_i)
            MODE_W13: begin
                if (ev_main_i) begin
                    if (lo_q[LOW13_W-1:0] == LOW_FULL) begin
                        lo_n[LOW13_W-1:0] = '0;
                        hi_n              = hi_q + 1'b1;
                        wrap_main_o       = &hi_q;
                    end else begin
                        lo_n[LOW13_W-1:0] = lo_q[LOW13_W-1:0] + 1'b1;
                    end
                end
            end
            MODE_W16: begin
                if (ev_main_i) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                    wrap_main_o  = &{hi_q, lo_q};
                end
            end
            MODE_RLD8: begin
                if (ev_main_i) begin
                    if (&lo_q) begin
                        lo_n        = hi_q;
                        wrap_main_o = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_OK) begin
                    if (ev_main_i) begin
                        lo_n        = lo_q + 1'b1;
                        wrap_main_o = &lo_q;
                    end
                    if (ev_hi_i) begin
                        hi_n      = hi_q + 1'b1;
                        wrap_hi_o = &hi_q;
                    end
                end
            end
        endcase
        if (wr_lo_i) lo_n = wdata_i;
        if (wr_hi_i) hi_n = wdata_i;
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_main_i && !ev_hi_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

    // R5
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RLD8 && ev_main_i && &lo_q && !wr_lo_i && !wr_hi_i)
        |=> (lo_q == $past(hi_q) && hi_q == $past(hi_q)));

    // R4
    w13_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_W13 && !wr_lo_i) |=> $stable(lo_q[BYTE_W-1:LOW13_W]));
endmodule

// File: rtl/twin_timer_counter.sv
module twin_timer_counter
    import tc_pkg::*;
#(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned LOW13_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        evt_pin_i,
    input  logic [1:0]        gate_pin_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o
);
    localparam int unsigned N_UNIT = 2;

    logic [BYTE_W-1:0]              mode_q;
    logic [N_UNIT-1:0]              run_q, flag_q, flag_set;
    logic [N_UNIT-1:0]              gate_lvl, evt_fall, evt_lvl_unused, gate_fall_unused;
    logic [N_UNIT-1:0]              ev_main, ev_hi, wrap_main, wrap_hi;
    logic [N_UNIT-1:0][BYTE_W-1:0]  lo_w, hi_w;
    logic                           wr_ctrl, u0_split;

    tc_pin_sync #(.W(N_UNIT)) i_evt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(evt_pin_i),
        .level_o(evt_lvl_unused), .fall_o(evt_fall));

    tc_pin_sync #(.W(N_UNIT)) i_gate_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i),
        .level_o(gate_lvl), .fall_o(gate_fall_unused));

    assign wr_ctrl  = bus_wr_i && (bus_addr_i == REG_CTRL);
    assign u0_split = (tc_mode_e'(mode_q[1:0]) == MODE_SPLIT);

    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(2 + 2 * u);
        localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(3 + 2 * u);
        tc_mode_e mode_u;
        logic     ext_sel, gate_en, src_ev;

        assign mode_u  = tc_mode_e'(mode_q[NIB_W*u +: 2]);
        assign ext_sel = mode_q[NIB_W*u + 2];
        assign gate_en = mode_q[NIB_W*u + 3];
        assign src_ev  = ext_sel ? evt_fall[u] : tick_i;
        assign ev_main[u] = run_q[u] && (!gate_en || gate_lvl[u]) && src_ev;
        assign ev_hi[u]   = (u == 0) ? (run_q[N_UNIT-1] && tick_i) : 1'b0;

        tc_unit #(.BYTE_W(BYTE_W), .LOW13_W(LOW13_W), .SPLIT_OK(u == 0)) i_unit (
            .clk(clk), .rst_n(rst_n), .mode_i(mode_u),
            .ev_main_i(ev_main[u]), .ev_hi_i(ev_hi[u]),
            .wr_lo_i(bus_wr_i && bus_addr_i == LO_ADDR),
            .wr_hi_i(bus_wr_i && bus_addr_i == HI_ADDR),
            .wdata_i(bus_wdata_i),
            .lo_o(lo_w[u]), .hi_o(hi_w[u]),
            .wrap_main_o(wrap_main[u]), .wrap_hi_o(wrap_hi[u]));
    end

    assign flag_set[0] = wrap_main[0];
    assign flag_set[1] = u0_split ? wrap_hi[0] : wrap_main[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr_i && bus_addr_i == REG_MODE) mode_q <= bus_wdata_i;
            if (wr_ctrl) begin
                run_q  <= bus_wdata_i[RUN_LSB +: N_UNIT];
                flag_q <= bus_wdata_i[FLAG_LSB +: N_UNIT];
            end
            for (int u = 0; u < N_UNIT; u++) begin
                if (flag_set[u]) flag_q[u] <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[RUN_LSB +: N_UNIT]  = run_q;
                bus_rdata_o[FLAG_LSB +: N_UNIT] = flag_q;
            end
            REG_MODE: bus_rdata_o = mode_q;
            REG_LO0:  bus_rdata_o = lo_w[0];
            REG_HI0:  bus_rdata_o = hi_w[0];
            REG_LO1:  bus_rdata_o = lo_w[1];
            REG_HI1:  bus_rdata_o = hi_w[1];
            default:  bus_rdata_o = '0;
        endcase
    end

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_main[0] |=> flag_q[0]);

    // R11
    split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (u0_split && wrap_main[1] && !wrap_hi[0] && !wr_ctrl) |=> $stable(flag_q[1]));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata_i[FLAG_LSB] && !wrap_main[0]) |=> !flag_q[0]);
endmodule

// File: tb/test_twin_timer_counter.sv
module test_twin_timer_counter;
    import tc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] evt_pin_i = 2'b11;
    logic [1:0] gate_pin_i = 2'b00;
    logic       bus_wr_i = 1'b0;
    logic [2:0] bus_addr_i = '0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twin_timer_counter i_twin_timer_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_pin_i(evt_pin_i),
        .gate_pin_i(gate_pin_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o));

    task automatic check(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    int starts16[4] = '{0, 'h12F0, 'hFFFE, 'h7FFF};
    int nlist[3]    = '{1, 3, 37};
    int w13_hi[3]   = '{'h05, 'hFF, 'hFF};
    int w13_lo[3]   = '{'hFE, 'h1F, 'hFD};
    int rl_hi[3]    = '{'hC0, 'h00, 'hFF};
    int rl_lo[3]    = '{'hFD, 'hFE, 'hFF};
    int rl_n[3]     = '{5, 300, 4};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, got hang expected end");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo, hi, c;
        int s, n, t, u3, rlo, rfl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int a = 0; a < 6; a++) begin
            rd(3'(a), c);
            check("R1 reset value", c, 0);
        end

        wr(REG_MODE, 8'hA5); rd(REG_MODE, c); check("R2 mode readback", c, 'hA5);
        wr(REG_LO1, 8'h3C);  rd(REG_LO1, c);  check("R2 counter readback", c, 'h3C);
        wr(REG_CTRL, 8'hFF); rd(REG_CTRL, c); check("R2 ctrl defined bits", c, 'h33);
        wr(REG_CTRL, 8'h00); wr(REG_LO1, 8'h00);

        // R3 sweep: 16-bit mode
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 3; j++) begin
                s = starts16[i]; n = nlist[j]; t = s + n;
                wr(REG_MODE, 8'h01); wr(REG_CTRL, 8'h01);
                wr(REG_LO0, s[7:0]); wr(REG_HI0, s[15:8]);
                ticks(n);
                rd(REG_LO0, lo); rd(REG_HI0, hi); rd(REG_CTRL, c);
                check("R3 16-bit count", {hi, lo}, t & 'hFFFF);
                check("R3 16-bit flag", c[4], (t > 'hFFFF) ? 1 : 0);
            end
        end

        // R4 sweep: 13-bit mode
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                n = nlist[j];
                u3 = w13_lo[i] >> 5;
                t = (w13_hi[i] << 5) + (w13_lo[i] & 'h1F) + n;
                wr(REG_MODE, 8'h00); wr(REG_CTRL, 8'h01);
                wr(REG_LO0, w13_lo[i][7:0]); wr(REG_HI0, w13_hi[i][7:0]);
                ticks(n);
                rd(REG_LO0, lo); rd(REG_HI0, hi); rd(REG_CTRL, c);
                check("R4 13-bit low", lo, (u3 << 5) | (t & 'h1F));
                check("R4 13-bit high", hi, (t >> 5) & 'hFF);
                check("R4 13-bit flag", c[4], (t > 'h1FFF) ? 1 : 0);
            end
        end

        // R5 cases: auto-reload
        for (int i = 0; i < 3; i++) begin
            rlo = rl_lo[i]; rfl = 0;
            for (int k = 0; k < rl_n[i]; k++) begin
                if (rlo == 'hFF) begin rlo = rl_hi[i]; rfl = 1; end
                else rlo = rlo + 1;
            end
            wr(REG_MODE, 8'h02); wr(REG_CTRL, 8'h01);
            wr(REG_LO0, rl_lo[i][7:0]); wr(REG_HI0, rl_hi[i][7:0]);
            ticks(rl_n[i]);
            rd(REG_LO0, lo); rd(REG_HI0, hi); rd(REG_CTRL, c);
            check("R5 reload low", lo, rlo);
            check("R5 reload high", hi, rl_hi[i]);
            check("R5 reload flag", c[4], rfl);
        end

        // R6: run bit off
        wr(REG_MODE, 8'h01); wr(REG_CTRL, 8'h00);
        wr(REG_LO0, 8'h40); wr(REG_HI0, 8'h00);
        ticks(10);
        rd(REG_LO0, lo); check("R6 stopped unit holds", lo, 'h40);

        // R7: gating
        wr(REG_MODE, 8'h09); wr(REG_CTRL, 8'h01);
        wr(REG_LO0, 8'h00); wr(REG_HI0, 8'h01);
        ticks(10);
        rd(REG_LO0, lo); check("R7 gate low blocks", lo, 0);
        gate_pin_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        ticks(10);
        rd(REG_LO0, lo); rd(REG_HI0, hi);
        check("R7 gate high counts", {hi, lo}, 'h010A);
        gate_pin_i[0] = 1'b0;

        // R8: external falling edges, tick held high
        wr(REG_MODE, 8'h05); wr(REG_CTRL, 8'h01);
        wr(REG_LO0, 8'h20); wr(REG_HI0, 8'h00);
        @(negedge clk); tick_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); evt_pin_i[0] = 1'b0;
            repeat (3) @(negedge clk);
            evt_pin_i[0] = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick_i = 1'b0;
        rd(REG_LO0, lo); check("R8 event count", lo, 'h26);

        // R9: clear by zero write, and set-wins priority
        wr(REG_MODE, 8'h01); wr(REG_CTRL, 8'h01);
        wr(REG_LO0, 8'hFF); wr(REG_HI0, 8'hFF);
        ticks(1);
        rd(REG_CTRL, c); check("R9 flag set by wrap", c, 'h11);
        wr(REG_CTRL, 8'h01);
        rd(REG_CTRL, c); check("R9 flag cleared by write", c, 'h01);
        wr(REG_LO0, 8'hFF); wr(REG_HI0, 8'hFF);
        @(negedge clk);
        tick_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = REG_CTRL; bus_wdata_i = 8'h01;
        @(negedge clk);
        tick_i = 1'b0; bus_wr_i = 1'b0;
        rd(REG_CTRL, c); check("R9 hardware set wins", c, 'h11);

        // R10 / R11: split mode
        wr(REG_MODE, 8'h13); wr(REG_CTRL, 8'h01);
        wr(REG_LO0, 8'h10); wr(REG_HI0, 8'h20);
        wr(REG_LO1, 8'hFF); wr(REG_HI1, 8'hFF);
        ticks(3);
        rd(REG_LO0, lo); rd(REG_HI0, hi);
        check("R10 split low under run0", lo, 'h13);
        check("R10 split high idle", hi, 'h20);
        wr(REG_CTRL, 8'h02);
        ticks(3);
        rd(REG_LO0, lo); rd(REG_HI0, hi);
        check("R10 split low idle", lo, 'h13);
        check("R10 split high under run1", hi, 'h23);
        rd(REG_LO1, lo); rd(REG_HI1, hi);
        check("R11 unit1 still counts", {hi, lo}, 'h0002);
        rd(REG_CTRL, c); check("R11 unit1 wrap not flagged", c, 'h02);
        wr(REG_HI0, 8'hFF);
        ticks(1);
        rd(REG_HI0, hi); rd(REG_CTRL, c);
        check("R10 split high wraps", hi, 0);
        check("R10 split high sets flag1", c, 'h22);
        wr(REG_CTRL, 8'h01); wr(REG_LO0, 8'hFF);
        ticks(1);
        rd(REG_LO0, lo); rd(REG_CTRL, c);
        check("R10 split low wraps", lo, 0);
        check("R10 split low sets flag0", c, 'h11);

        // R12: unit 1 in split mode holds
        wr(REG_MODE, 8'h31); wr(REG_CTRL, 8'h02);
        wr(REG_LO1, 8'h05); wr(REG_HI1, 8'h06);
        ticks(5);
        rd(REG_LO1, lo); rd(REG_HI1, hi); rd(REG_CTRL, c);
        check("R12 unit1 split holds", {hi, lo}, 'h0605);
        check("R12 no flag", c, 'h02);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule